// File: doc/BRIEF.md
# Sampled Sensor Serial Slave Port

This block is the device side of a four-channel sampled sensor's serial port. A host lowers an active-low select line and issues sixteen serial clocks. The port sends data on falling clock edges, and the host samples it on rising edges. On each falling edge the port also samples the host's serial input. The block's own system clock oversamples the serial clock, the select and the serial input through synchronizers, and all transfer logic runs on that clock.

Each transfer returns one 16-bit word: two zero bits, then the 2-bit address of the reported channel, then a 12-bit result, most significant bit first. At the same time the host sends a 12-bit control word. If the leading bit of that word is set, the word updates a small register that holds the channel address and the output coding. The register takes effect only when the transfer completes. The channel-select output moves to the new address on the fourteenth falling edge. An aborted transfer returns the select output to the registered address. The result is captured from the parallel sample inputs when select falls. It is either the raw sample (straight binary) or the sample with its top bit inverted (twos complement).

Top module: `snsr_spi_port`

## Requirements
- R1: After reset the output enable is low, the channel select is 00 and the coding is straight binary.
- R2: A transfer sends 0, 0, the two address bits of the captured channel, then result bits 11 down to 0. The first bit is driven from select falling, and each later bit appears after the next serial clock falling edge.
- R3: The output enable is high from select falling until the 16th falling edge. After the 16th falling edge, and whenever select is high, it is low.
- R4: A control word with leading bit (bit 11) equal to 1 is committed. A leading bit of 0 leaves the address and coding unchanged.
- R5: In the control word, bits 7:6 are the channel address and bit 0 is the coding (1 = straight binary, 0 = twos complement). All other bits after bit 11 have no effect.
- R6: Serial input values on falling edges 13 to 16 have no effect.
- R7: Address 00 reports sample slice 0 (rate), 01 slice 1 (temperature), 10 slice 2 (auxiliary 1) and 11 slice 3 (auxiliary 2). Slice k is bits 12k+11 down to 12k of the sample bus.
- R8: On the 14th falling edge the channel select output takes the newly written address. Without a write it stays where it is. The next transfer reports that channel.
- R9: If select rises before the 16th falling edge, the output enable drops, the register keeps its old contents and the channel select returns to the registered address.
- R10: Straight binary sends the sample unchanged, and twos complement sends it with bit 11 inverted. A new coding applies from the next transfer onward.
- R11: The result is captured when select falls. Later changes on the sample inputs during that transfer do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from host, idle high |
| csn_i | input | 1 | Active-low transfer select |
| sdi_i | input | 1 | Serial control input |
| samples_i | input | 48 | Four 12-bit channel samples, channel k at bits 12k+11:12k |
| sdo_o | output | 1 | Serial result output |
| sdo_oe_o | output | 1 | Output enable for the serial result pin driver |
| ch_sel_o | output | 2 | Channel select for the sampling multiplexer |

## Verification
The bench builds the block with its defaults: 12-bit samples, four channels and two synchronizer stages. At these values every address code, both codings and the all-zero and all-one sample boundaries can be reached with a few dozen transfers. The serial clock runs at one sixteenth of the system clock, so the synchronizer delay sits well inside each half period. This allows the select output to be observed between the 14th and 16th edges. Aborts are placed after the 14th edge and after the 5th, and one transfer changes the sample inputs mid-flight.

// File: rtl/snsr_spi_pkg.sv
package snsr_spi_pkg;
  // control word geometry (host sends bit CW-1 first)
  localparam int CW         = 12;
  localparam int WR_BIT     = 11;
  localparam int ADDR_LO    = 6;
  localparam int CODING_BIT = 0;
  // number of leading zero bits in the result word
  localparam int PAD_W      = 2;

  typedef enum logic {
    CODE_TWOS = 1'b0,
    CODE_BIN  = 1'b1
  } coding_e;
endpackage

// File: rtl/snsr_sync.sv
module snsr_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/snsr_ctl_reg.sv
module snsr_ctl_reg
  import snsr_spi_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int FRAME_LEN = 16,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_fall,
  input  logic [CNT_W-1:0]  edge_cnt,
  input  logic              sdi,
  output logic [ADDR_W-1:0] reg_addr_o,
  output coding_e           reg_coding_o,
  output logic [ADDR_W-1:0] sel_o
);
  localparam int ADDR_HI = ADDR_LO + ADDR_W - 1;
  localparam logic [CNT_W-1:0] E_WR     = CNT_W'(CW - 1 - WR_BIT);
  localparam logic [CNT_W-1:0] E_ADDR_A = CNT_W'(CW - 1 - ADDR_HI);
  localparam logic [CNT_W-1:0] E_ADDR_B = CNT_W'(CW - 1 - ADDR_LO);
  localparam logic [CNT_W-1:0] E_CODE   = CNT_W'(CW - 1 - CODING_BIT);
  localparam logic [CNT_W-1:0] E_SEL    = CNT_W'(FRAME_LEN - 3);
  localparam logic [CNT_W-1:0] E_END    = CNT_W'(FRAME_LEN - 1);

  logic              wr_flag;
  logic [ADDR_W-1:0] addr_sh;
  logic              code_sh;
  logic [ADDR_W-1:0] reg_addr_q;
  coding_e           reg_coding_q;
  logic [ADDR_W-1:0] sel_q;

  // capture of the incoming control word fields
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_flag <= 1'b0;
      addr_sh <= '0;
      code_sh <= 1'b1;
    end else if (cs_fall) begin
      wr_flag <= 1'b0;
    end else if (sclk_fall) begin
      if (edge_cnt == E_WR) wr_flag <= sdi;
      if (edge_cnt >= E_ADDR_A && edge_cnt <= E_ADDR_B)
        addr_sh <= (addr_sh << 1) | ADDR_W'(sdi);
      if (edge_cnt == E_CODE) code_sh <= sdi;
    end
  end

  // committed register: only at the final edge of a full transfer
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_addr_q   <= '0;
      reg_coding_q <= CODE_BIN;
    end else if (sclk_fall && edge_cnt == E_END && wr_flag) begin
      reg_addr_q   <= addr_sh;
      reg_coding_q <= coding_e'(code_sh);
    end
  end

  // multiplexer select: early switch, reverts on abort
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (cs_rise) begin
      sel_q <= reg_addr_q;
    end else if (sclk_fall && edge_cnt == E_SEL && wr_flag) begin
      sel_q <= addr_sh;
    end
  end

  assign reg_addr_o   = reg_addr_q;
  assign reg_coding_o = reg_coding_q;
  assign sel_o        = sel_q;

  // R4: a transfer without the write bit keeps the register
  p_nowrite_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (sclk_fall && edge_cnt == E_END && !wr_flag) |=>
      ($stable(reg_addr_q) && $stable(reg_coding_q)));

  // R9: aborted transfer: register unchanged, select back on it
  p_abort_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && edge_cnt < CNT_W'(FRAME_LEN)) |=>
      ($stable(reg_addr_q) && $stable(reg_coding_q) && sel_q == reg_addr_q));

  // R8: without a write the select does not move at the switch edge
  p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sclk_fall && edge_cnt == E_SEL && !wr_flag) |=> $stable(sel_q));
endmodule

// File: rtl/snsr_tx_shift.sv
module snsr_tx_shift
  import snsr_spi_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_fall,
  input  logic                   cs_rise,
  input  logic                   sclk_fall,
  input  logic [CNT_W-1:0]       edge_cnt,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  coding_e                reg_coding_i,
  input  logic [N_CH*DATA_W-1:0] samples_i,
  output logic                   sdo_o,
  output logic                   oe_o
);
  localparam int FRAME_LEN = PAD_W + ADDR_W + DATA_W;
  localparam logic [CNT_W-1:0] E_END = CNT_W'(FRAME_LEN - 1);

  logic [DATA_W-1:0]    ch_arr [N_CH];
  logic [DATA_W-1:0]    raw;
  logic [DATA_W-1:0]    coded;
  logic [FRAME_LEN-1:0] shift_q;
  logic                 oe_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign ch_arr[g] = samples_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    raw   = ch_arr[reg_addr_i];
    coded = raw;
    if (reg_coding_i == CODE_TWOS) coded[DATA_W-1] = ~raw[DATA_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      oe_q    <= 1'b0;
    end else if (cs_fall) begin
      shift_q <= {{PAD_W{1'b0}}, reg_addr_i, coded};
      oe_q    <= 1'b1;
    end else if (cs_rise) begin
      oe_q    <= 1'b0;
    end else if (sclk_fall && edge_cnt <= E_END) begin
      if (edge_cnt == E_END) oe_q <= 1'b0;
      else shift_q <= {shift_q[FRAME_LEN-2:0], 1'b0};
    end
  end

  assign sdo_o = shift_q[FRAME_LEN-1];
  assign oe_o  = oe_q;

  // R2: a transfer opens with an enabled zero bit
  p_lead_zero_r2: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (oe_q && !sdo_o));

  // R3: driver released after the final edge and on select rising
  p_end_hiz_r3: assert property (@(posedge clk) disable iff (rst)
    (sclk_fall && edge_cnt == E_END) |=> !oe_q);
  p_idle_hiz_r3: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !oe_q);
endmodule

// File: rtl/snsr_spi_port.sv
module snsr_spi_port
  import snsr_spi_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sclk_i,
  input  logic                          csn_i,
  input  logic                          sdi_i,
  input  logic [N_CH*DATA_W-1:0]        samples_i,
  output logic                          sdo_o,
  output logic                          sdo_oe_o,
  output logic [$clog2(N_CH)-1:0]       ch_sel_o
);
  localparam int ADDR_W    = $clog2(N_CH);
  localparam int FRAME_LEN = PAD_W + ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_LEN);

  // bit order: {sdi, csn, sclk}; lines idle high except sdi
  logic [2:0] sync_q;
  logic       s_sclk, s_csn, s_sdi;
  logic       sclk_d, csn_d;
  logic       cs_fall, cs_rise, sclk_fall;
  logic [CNT_W-1:0] edge_cnt;
  logic [ADDR_W-1:0] reg_addr;
  coding_e           reg_coding;

  snsr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sdi_i, csn_i, sclk_i}),
    .q_o (sync_q)
  );
  assign {s_sdi, s_csn, s_sclk} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= s_sclk;
      csn_d  <= s_csn;
    end
  end

  assign cs_fall   = csn_d & ~s_csn;
  assign cs_rise   = ~csn_d & s_csn;
  assign sclk_fall = sclk_d & ~s_sclk & ~s_csn & ~csn_d;

  // falling edges seen since select fell, saturating
  always_ff @(posedge clk) begin
    if (rst)                                 edge_cnt <= '0;
    else if (cs_fall)                        edge_cnt <= '0;
    else if (sclk_fall && edge_cnt < CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
  end

  snsr_ctl_reg #(.ADDR_W(ADDR_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .cs_fall      (cs_fall),
    .cs_rise      (cs_rise),
    .sclk_fall    (sclk_fall),
    .edge_cnt     (edge_cnt),
    .sdi          (s_sdi),
    .reg_addr_o   (reg_addr),
    .reg_coding_o (reg_coding),
    .sel_o        (ch_sel_o)
  );

  snsr_tx_shift #(.DATA_W(DATA_W), .N_CH(N_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .cs_fall      (cs_fall),
    .cs_rise      (cs_rise),
    .sclk_fall    (sclk_fall),
    .edge_cnt     (edge_cnt),
    .reg_addr_i   (reg_addr),
    .reg_coding_i (reg_coding),
    .samples_i    (samples_i),
    .sdo_o        (sdo_o),
    .oe_o         (sdo_oe_o)
  );

  // R3: edge counter never passes the transfer length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= CNT_MAX);

  // R1: reset leaves the driver off and channel 0 selected
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!sdo_oe_o && ch_sel_o == '0));
endmodule

// File: tb/snsr_spi_port_bench.sv
module snsr_spi_port_bench;
  localparam int DATA_W = 12;
  localparam int N_CH   = 4;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_i = 1'b1;
  logic csn_i = 1'b1;
  logic sdi_i = 1'b0;
  logic [N_CH*DATA_W-1:0] samples_i = '0;
  logic sdo_o, sdo_oe_o;
  logic [1:0] ch_sel_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] expq [$];
  logic [1:0]  ref_addr = 2'b00;
  logic        ref_bin  = 1'b1;

  always #2 clk = ~clk;

  snsr_spi_port u_snsr_spi_port (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
    .samples_i(samples_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .ch_sel_o(ch_sel_o)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_samples(input logic [11:0] a, input logic [11:0] b,
                             input logic [11:0] c, input logic [11:0] d);
    samples_i = {d, c, b, a};
  endtask

  // monitor: bits sampled just before each falling edge while selected
  logic [15:0] got;
  int nb = 0;
  always @(negedge csn_i) begin
    nb = 0; got = '0;
  end
  always @(negedge sclk_i) begin
    if (!csn_i && nb < 16) begin
      got = {got[14:0], sdo_o};
      nb++;
      if (!sdo_oe_o) chk(1'b0, "R3 enable during frame", 16'(sdo_oe_o), 16'd1);
    end
  end
  always @(posedge csn_i) begin
    if (nb == 16) begin
      if (expq.size() == 0) chk(1'b0, "R2 unexpected frame", got, 16'hxxxx);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(got === e, "R2 R7 R10 frame word", got, e);
      end
    end
  end

  // driver: one transfer of n clocks carrying control word w
  task automatic xfer(input logic [11:0] w, input int n, input bit chg);
    logic [11:0] raw;
    logic [11:0] cod;
    logic [1:0]  sel_exp;
    raw = samples_i[ref_addr*DATA_W +: DATA_W];
    cod = ref_bin ? raw : {~raw[11], raw[10:0]};
    if (n == 16) expq.push_back({2'b00, ref_addr, cod});
    sel_exp = w[11] ? w[7:6] : ref_addr;
    csn_i = 1'b0;
    wait_clk(HALF);
    chk(sdo_oe_o === 1'b1, "R3 enable after select", 16'(sdo_oe_o), 16'd1);
    for (int i = 0; i < n; i++) begin
      sdi_i = (i < 12) ? w[11-i] : i[0];  // R6: noise on trailing bits
      wait_clk(2);
      sclk_i = 1'b0;
      if (chg && i == 3) set_samples(12'h111, 12'h222, 12'h333, 12'h444);
      wait_clk(HALF);
      sclk_i = 1'b1;
      wait_clk(HALF - 2);
      if (i == 13) chk(ch_sel_o === sel_exp, "R8 select at edge 14", 16'(ch_sel_o), 16'(sel_exp));
      if (i == 15) chk(sdo_oe_o === 1'b0, "R3 release after edge 16", 16'(sdo_oe_o), 16'd0);
    end
    csn_i = 1'b1;
    if (n == 16 && w[11]) begin
      ref_addr = w[7:6];
      ref_bin  = w[0];
    end
    wait_clk(2 * HALF);
    chk(sdo_oe_o === 1'b0, "R3 R9 idle enable", 16'(sdo_oe_o), 16'd0);
    chk(ch_sel_o === ref_addr, "R4 R9 select after frame", 16'(ch_sel_o), 16'(ref_addr));
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_samples(12'hA53, 12'h5C0, 12'h000, 12'hFFF);
    wait_clk(5);
    rst = 1'b0;
    wait_clk(10);
    chk(sdo_oe_o === 1'b0, "R1 reset enable", 16'(sdo_oe_o), 16'd0);
    chk(ch_sel_o === 2'b00, "R1 reset select", 16'(ch_sel_o), 16'd0);

    xfer(12'h000, 16, 1'b0);   // R1: channel 0, straight binary
    xfer(12'h871, 16, 1'b0);   // R4 R5: write addr 01 binary
    xfer(12'hBBC, 16, 1'b0);   // R5: addr 10 twos, don't-cares set
    xfer(12'h0F1, 16, 1'b0);   // R4: no write bit, ch2 twos reported
    xfer(12'h8F1, 16, 1'b0);   // R7: addr 11 binary (ch2 twos reported)
    xfer(12'h831, 14, 1'b0);   // R9: abort after edge 14 writing 00
    xfer(12'h870, 5, 1'b0);    // R9: abort after edge 5
    xfer(12'h870, 16, 1'b1);   // R11: ch3 captured, samples change mid-frame
    xfer(12'h831, 16, 1'b0);   // R10: ch1 twos of new sample
    xfer(12'h000, 16, 1'b0);   // ch0 binary
    set_samples(12'h800, 12'h7FF, 12'h000, 12'hFFF);
    xfer(12'h830, 16, 1'b0);   // R10: ch0 binary 800, then twos
    xfer(12'h000, 16, 1'b0);   // ch0 twos: 800 -> 000
    xfer(12'h8B0, 16, 1'b0);   // R7: to addr 10 twos
    xfer(12'h8F0, 16, 1'b0);   // ch2 twos of 000 -> 800
    xfer(12'h000, 16, 1'b0);   // ch3 twos of FFF -> 7FF

    wait_clk(20);
    chk(expq.size() == 0, "R2 all frames seen", 16'(expq.size()), 16'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule